// File: doc/BRIEF.md
# DMA Transfer Submission Register Front-End

This block is the software-facing side of a single-channel DMA engine. A processor programs the next request (flags and a row length) through a 32-bit register port. It reads the identifier that the request will receive, then writes the start register to place the request in a small queue. The datapath takes requests from the head of the queue through a valid/ready handshake. It reports each finished transfer by returning its identifier on a done strobe.

Identifiers roll over modulo 32. Completions collect in a 32-bit bitmap, with one bit for each identifier. The bit of an identifier is cleared again when that identifier is handed out once more. Two interrupt causes are kept: a queue slot being taken by the datapath, and a transfer finishing. Each cause has a mask bit and a write-one-to-clear pending bit. A single interrupt line is asserted for any pending cause that is not masked. Software can tell that the queue is full by reading the start register.

Top module: `dma_submit_regs`

## Requirements
- R1: After a synchronous reset, the next identifier reads 0, the completion bitmap reads 0, the pending register reads 0, the mask register reads 3 (both causes masked), the start register reads 0, and `irq` and `req_valid` are low.
- R2: Control register at 0x400: bit 0 is run, bit 1 is hold and bit 2 is descriptor-chain mode. All three read back as written. `req_valid` is high only while the queue is non-empty, run is 1 and hold is 0.
- R3: A write to 0x408 with bit 0 set queues one request when run is 1 and the queue is not full. The request carries the identifier shown at 0x404 and the current flags and length. The identifier then increments modulo 32. A start while run is 0 or while the queue is full is dropped and leaves 0x404 unchanged.
- R4: A read of 0x408 returns 1 while the queue holds DEPTH requests and 0 otherwise.
- R5: Queued requests appear on `req_id`/`req_flags`/`req_xlen` in the order they were queued. The head stays stable until it is taken with `req_valid` and `req_ready` both high.
- R6: Writing the control register with bit 0 clear empties the queue in the same cycle. `req_valid` stays low after that until a new request is queued.
- R7: A `done_valid` pulse sets bit `done_id` of the bitmap at 0x428. Queuing a request clears the bitmap bit of the identifier it receives.
- R8: Flags register at 0x40C: bit 0 is repeat, bit 1 is end-of-packet and bit 2 is partial-length report. Bits not enabled by FLAG_IMPL (default: bit 2 absent) read back as 0.
- R9: Length register at 0x418 stores the written value with its low ALIGN_BITS bits forced to 1. Writing all ones reads back 2^XLEN_W-1 (the largest length minus one). Writing 0 reads back the alignment mask.
- R10: Pending register at 0x84: bit 0 is set when the datapath takes a request, and bit 1 when `done_valid` arrives. Writing ones clears the matching bits. 0x80 holds the mask and 0x88 reads pending AND NOT mask. `irq` is high one cycle after any pending bit is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_run | output | 1 | Control bit 0 toward the datapath |
| eng_hold | output | 1 | Control bit 1 toward the datapath |
| eng_chain | output | 1 | Control bit 2 toward the datapath |
| req_valid | output | 1 | Queue head is offered |
| req_ready | input | 1 | Datapath takes the head |
| req_id | output | 5 | Identifier of the head request |
| req_flags | output | 3 | Flags of the head request |
| req_xlen | output | XLEN_W | Length-minus-one of the head request |
| done_valid | input | 1 | A transfer finished |
| done_id | input | 5 | Identifier of the finished transfer |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the reuse of an identifier whose completion bit is still set. This needs 32 allocations between two uses of the same value. The stimulus marks identifiers 0 and 2 complete, then streams 28 back-to-back starts with the datapath always ready so that the queue never fills. One further start lands on identifier 0 again, and the bitmap must then show only identifier 2. A full queue is reached by holding the datapath off, so that the dropped fifth start and the full readback can both be seen.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int ID_W = 5;
  localparam int NUM_IDS = 1 << ID_W;

  localparam int OFF_IRQ_MASK = 'h080;
  localparam int OFF_IRQ_PEND = 'h084;
  localparam int OFF_IRQ_SRC  = 'h088;
  localparam int OFF_CTRL     = 'h400;
  localparam int OFF_NEXT_ID  = 'h404;
  localparam int OFF_START    = 'h408;
  localparam int OFF_FLAGS    = 'h40C;
  localparam int OFF_XLEN     = 'h418;
  localparam int OFF_DONE     = 'h428;

  localparam int IRQ_SLOT = 0;
  localparam int IRQ_FIN  = 1;
  localparam int N_IRQ    = 2;

  typedef struct packed {
    logic chain;
    logic hold;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dsr_fifo.sv
module dsr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic                           full,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/dsr_irq.sv
module dsr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_mask) mask <= wdata;
      pend <= (pend & ~(wr_clr ? wdata : '0)) | set;
      irq  <= |(pend & ~mask);
    end
  end
endmodule

// File: rtl/dma_submit_regs.sv
module dma_submit_regs
  import dsr_pkg::*;
#(
  parameter int         DEPTH      = 4,
  parameter int         XLEN_W     = 16,
  parameter int         ALIGN_BITS = 2,
  parameter logic [2:0] FLAG_IMPL  = 3'b011,
  parameter int         ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_run,
  output logic              eng_hold,
  output logic              eng_chain,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [4:0]        req_id,
  output logic [2:0]        req_flags,
  output logic [XLEN_W-1:0] req_xlen,
  input  logic              done_valid,
  input  logic [4:0]        done_id,
  output logic              irq
);
  localparam int QW = ID_W + 3 + XLEN_W;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [XLEN_W-1:0] ALIGN_MASK = XLEN_W'((1 << ALIGN_BITS) - 1);

  ctrl_t               ctrl_q;
  logic [2:0]          flags_q;
  logic [XLEN_W-1:0]   xlen_q;
  logic [ID_W-1:0]     next_id;
  logic [NUM_IDS-1:0]  done_map;
  logic [N_IRQ-1:0]    mask, pend, irq_set;
  logic [CNT_W-1:0]    q_count;
  logic                q_full, q_empty;
  logic [QW-1:0]       q_head;
  logic                wr_hit_ctrl, flush, push, pop;
  logic [31:0]         rd_mux;
  logic                unused_wdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign unused_wdata = &{1'b0, reg_wdata};

  assign wr_hit_ctrl = reg_wr && hit(reg_addr, OFF_CTRL);
  assign flush       = wr_hit_ctrl && !reg_wdata[0];
  assign push        = reg_wr && hit(reg_addr, OFF_START) && reg_wdata[0]
                       && ctrl_q.run && !q_full;
  assign req_valid   = !q_empty && ctrl_q.run && !ctrl_q.hold;
  assign pop         = req_valid && req_ready;

  assign eng_run   = ctrl_q.run;
  assign eng_hold  = ctrl_q.hold;
  assign eng_chain = ctrl_q.chain;

  // Request queue
  dsr_fifo #(.DEPTH(DEPTH), .W(QW)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (push),
    .din   ({next_id, flags_q, xlen_q}),
    .pop   (pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty),
    .count (q_count)
  );
  assign {req_id, req_flags, req_xlen} = q_head;

  // Interrupt causes
  assign irq_set[IRQ_SLOT] = pop;
  assign irq_set[IRQ_FIN]  = done_valid;

  dsr_irq #(.N(N_IRQ)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set     (irq_set),
    .wr_mask (reg_wr && hit(reg_addr, OFF_IRQ_MASK)),
    .wr_clr  (reg_wr && hit(reg_addr, OFF_IRQ_PEND)),
    .wdata   (reg_wdata[N_IRQ-1:0]),
    .mask    (mask),
    .pend    (pend),
    .irq     (irq)
  );

  // Programmed state, identifier counter, completion bitmap
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      flags_q  <= '0;
      xlen_q   <= ALIGN_MASK;
      next_id  <= '0;
      done_map <= '0;
    end else begin
      if (wr_hit_ctrl) ctrl_q <= ctrl_t'(reg_wdata[2:0]);
      if (reg_wr && hit(reg_addr, OFF_FLAGS)) flags_q <= reg_wdata[2:0] & FLAG_IMPL;
      if (reg_wr && hit(reg_addr, OFF_XLEN))  xlen_q <= reg_wdata[XLEN_W-1:0] | ALIGN_MASK;
      if (done_valid) done_map[done_id] <= 1'b1;
      if (push) begin
        done_map[next_id] <= 1'b0;
        next_id           <= next_id + 1'b1;
      end
    end
  end

  // Read path, registered
  always_comb begin
    rd_mux = '0;
    if (hit(reg_addr, OFF_IRQ_MASK)) rd_mux = 32'(mask);
    if (hit(reg_addr, OFF_IRQ_PEND)) rd_mux = 32'(pend);
    if (hit(reg_addr, OFF_IRQ_SRC))  rd_mux = 32'(pend & ~mask);
    if (hit(reg_addr, OFF_CTRL))     rd_mux = 32'(ctrl_q);
    if (hit(reg_addr, OFF_NEXT_ID))  rd_mux = 32'(next_id);
    if (hit(reg_addr, OFF_START))    rd_mux = 32'(q_full);
    if (hit(reg_addr, OFF_FLAGS))    rd_mux = 32'(flags_q);
    if (hit(reg_addr, OFF_XLEN))     rd_mux = 32'(xlen_q);
    if (hit(reg_addr, OFF_DONE))     rd_mux = 32'(done_map);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       push,
  input logic                       flush,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic [4:0]                 next_id,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [4:0]                 req_id,
  input logic                       done_valid,
  input logic [4:0]                 done_id,
  input logic [31:0]                done_map,
  input logic [1:0]                 pend,
  input logic [1:0]                 mask,
  input logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  // R4: occupancy never passes the depth
  p_queue_bound_r4: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  // R3: each accepted start advances the identifier by one, modulo 32
  p_id_step_r3: assert property (@(posedge clk) disable iff (rst)
    push |=> next_id == 5'($past(next_id) + 5'd1));

  // R3: no accepted start, no identifier change
  p_id_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(next_id));

  // R5: an offered head that is not taken stays put
  p_head_hold_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready && !flush |=> $stable(req_id));

  // R6: abort empties the queue
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> q_count == '0 && !req_valid);

  // R7: a completion sets its bitmap bit unless reallocated in the same cycle
  p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
    done_valid && !(push && next_id == done_id) |=> done_map[$past(done_id)]);

  // R10: a completion raises the finish cause
  p_fin_pend_r10: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> pend[1]);

  // R10: an unmasked pending finish cause drives the line
  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    pend[1] && !mask[1] |=> irq);
endmodule

bind dma_submit_regs dsr_checker #(.DEPTH(DEPTH)) u_dsr_checker (
  .clk        (clk),
  .rst        (rst),
  .push       (push),
  .flush      (flush),
  .q_count    (q_count),
  .next_id    (next_id),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_id     (req_id),
  .done_valid (done_valid),
  .done_id    (done_id),
  .done_map   (done_map),
  .pend       (pend),
  .mask       (mask),
  .irq        (irq)
);

// File: tb/test_dma_submit_regs.sv
module test_dma_submit_regs;
  localparam int XW = 16;
  localparam int IW = 5 + 3 + XW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          eng_run, eng_hold, eng_chain;
  logic          req_valid, req_ready = 1'b0;
  logic [4:0]    req_id;
  logic [2:0]    req_flags;
  logic [XW-1:0] req_xlen;
  logic          done_valid = 1'b0;
  logic [4:0]    done_id = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [IW-1:0] sb[$];
  logic [4:0]    exp_id = '0;
  logic [2:0]    cur_flags = '0;
  logic [XW-1:0] cur_xlen = '0;
  logic [31:0]   rd;

  always #4 clk = ~clk;

  dma_submit_regs i_dma_submit_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_run(eng_run),
    .eng_hold(eng_hold), .eng_chain(eng_chain), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .req_flags(req_flags),
    .req_xlen(req_xlen), .done_valid(done_valid), .done_id(done_id), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // Driver: a start that the requirements say is accepted pushes its expected request
  task automatic start(input logic accepted);
    if (accepted) begin
      sb.push_back({exp_id, cur_flags, cur_xlen});
      exp_id = exp_id + 5'd1;
    end
    wr(12'h408, 32'd1);
  endtask

  task automatic finish_test;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: compare each request taken by the stub datapath (R5)
  always @(negedge clk) begin
    #1;
    if (!rst && req_valid === 1'b1 && req_ready === 1'b1) begin
      if (sb.size() == 0) chk("R5 unexpected request", {8'd0, req_id, req_flags, req_xlen}, 32'hxxxxxxxx);
      else chk("R5 request order/content", 32'({req_id, req_flags, req_xlen}), 32'(sb.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdreg(12'h404, rd); chk("R1 next id", rd, 0);
    rdreg(12'h428, rd); chk("R1 done map", rd, 0);
    rdreg(12'h084, rd); chk("R1 pending", rd, 0);
    rdreg(12'h080, rd); chk("R1 mask", rd, 3);
    rdreg(12'h408, rd); chk("R1 start", rd, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_valid", 32'(req_valid), 0);

    // R8 flags, bit 2 not implemented
    wr(12'h40C, 32'h7); rdreg(12'h40C, rd); chk("R8 flags readback", rd, 3);
    // R9 length probing
    wr(12'h418, 32'hFFFF_FFFF); rdreg(12'h418, rd); chk("R9 max length", rd, 32'hFFFF);
    wr(12'h418, 32'h0); rdreg(12'h418, rd); chk("R9 align mask", rd, 3);

    // R2 control readback
    wr(12'h400, 32'h7); rdreg(12'h400, rd); chk("R2 control readback", rd, 7);
    chk("R2 chain output", 32'(eng_chain), 1);

    // R3/R4 fill queue while held
    wr(12'h400, 32'h3);
    wr(12'h40C, 32'h2); cur_flags = 3'h2;
    wr(12'h418, 32'h40); cur_xlen = 16'h43;
    for (int k = 0; k < 3; k++) start(1'b1);
    rdreg(12'h408, rd); chk("R4 start not full", rd, 0);
    start(1'b1);
    rdreg(12'h408, rd); chk("R4 start full", rd, 1);
    start(1'b0);
    rdreg(12'h404, rd); chk("R3 full start dropped", rd, 4);
    chk("R2 held no valid", 32'(req_valid), 0);

    // R5 release and drain
    wr(12'h400, 32'h1);
    req_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 queue drained", 32'(sb.size()), 0);
    rdreg(12'h084, rd); chk("R10 slot pending", rd, 1);
    rdreg(12'h088, rd); chk("R10 source masked", rd, 0);
    chk("R10 irq masked", 32'(irq), 0);
    wr(12'h080, 32'h0);
    @(negedge clk);
    chk("R10 irq unmasked", 32'(irq), 1);
    wr(12'h084, 32'h1);
    @(negedge clk);
    rdreg(12'h084, rd); chk("R10 w1c clear", rd, 0);
    chk("R10 irq after clear", 32'(irq), 0);

    // R7 completions
    done_valid = 1'b1; done_id = 5'd2; @(negedge clk);
    done_id = 5'd0; @(negedge clk);
    done_valid = 1'b0;
    rdreg(12'h428, rd); chk("R7 done bits", rd, 32'h5);
    rdreg(12'h084, rd); chk("R10 finish pending", rd, 2);
    chk("R10 irq finish", 32'(irq), 1);
    wr(12'h084, 32'h2);

    // R3 wrap and R7 clear on reuse
    for (int k = 0; k < 28; k++) start(1'b1);
    repeat (4) @(negedge clk);
    rdreg(12'h404, rd); chk("R3 id wrap", rd, 0);
    start(1'b1);
    repeat (4) @(negedge clk);
    rdreg(12'h428, rd); chk("R7 reuse clears bit", rd, 32'h4);
    chk("R5 all taken", 32'(sb.size()), 0);

    // R6 abort
    req_ready = 1'b0;
    start(1'b1); start(1'b1);
    @(negedge clk);
    chk("R6 valid before abort", 32'(req_valid), 1);
    wr(12'h400, 32'h0);
    sb.delete();
    chk("R6 valid after abort", 32'(req_valid), 0);
    start(1'b0);
    rdreg(12'h404, rd); chk("R3 start while stopped dropped", rd, 32'(exp_id));
    wr(12'h400, 32'h1);
    chk("R6 queue empty after restart", 32'(req_valid), 0);

    repeat (2) @(negedge clk);
    finish_test();
  end
endmodule